// File: doc/BRIEF.md
# Multi-Chain Multiplexed Scan Register Bank

This block is a bank of state flip-flops in which every flop has a 2:1 selector in front of its data pin. One test-control input picks the mode. In capture mode each flop loads its functional data input. In shift mode the flops form several independent serial chains. Each chain takes bits from its own serial input and passes them toward its own serial output. A tester loads a pattern through the chains, captures one functional cycle, and then unloads the captured state through the same chains.

The serial inputs and outputs use no dedicated pins. Chain k borrows primary input pin k as its serial input and primary output pin k as its serial output. The pin selectors follow the same test-control level as the flops. The number of chains and the length of each chain are parameters, and the chains may have different lengths.

The mode is decoded from `test_ctl` on every cycle and has two named values. `MODE_SCAN` applies while `test_ctl` is 0. `MODE_CAPTURE` applies while `test_ctl` is 1. There are only two transitions: the bank enters `MODE_SCAN` when `test_ctl` falls and enters `MODE_CAPTURE` when it rises. Each one takes effect at the next rising clock edge. All flops run on `clk`, which comes straight from a primary input.

Top module: `scan_bank`

## Requirements
- R1: When `test_ctl` is 1 and reset is low, every bit of `q` equals the value `func_d` had at the previous rising edge of `clk`.
- R2: When `test_ctl` is 0, a clock edge shifts each chain one place. Flop 0 of chain k loads `pi_pin[k]`, and flop i loads flop i-1 of the same chain. Chain k covers the bits of `q` starting at the sum of the lengths of chains 0 to k-1. With the default lengths 4, 3 and 2, the chains are `q[3:0]`, `q[6:4]` and `q[8:7]`.
- R3: While `test_ctl` is 0, `po_pin[k]` shows the last flop of chain k, in the same cycle, for each chain k.
- R4: While `test_ctl` is 1, `po_pin` equals `po_func` on every pin. Output pins with an index at or above the chain count carry `po_func` in both modes.
- R5: `pi_func` equals `pi_pin` in both modes, so the functional logic always sees the shared input pins.
- R6: Reset is synchronous and active high. A clock edge with `rst` at 1 clears every flop to 0, whatever the mode and the other inputs.
- R7: The chains are independent and may have different lengths. After a capture, chain k presents its captured bits at `po_pin[k]` from the last flop toward flop 0, one bit per shift. After that it presents the bits shifted in.
- R8: In shift mode `func_d` has no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, from a primary input |
| rst | input | 1 | Synchronous reset, active high |
| test_ctl | input | 1 | 0 selects shift mode, 1 selects capture mode |
| func_d | input | NBITS | Functional next-state inputs of the flops |
| q | output | NBITS | Flop outputs toward the functional logic |
| pi_pin | input | NUM_PI | Primary input pins; pin k is also the serial input of chain k |
| pi_func | output | NUM_PI | Input pin values passed to the functional logic |
| po_func | input | NUM_PO | Functional values for the primary output pins |
| po_pin | output | NUM_PO | Primary output pins; pin k is also the serial output of chain k |

## Verification
The hardest case to reach is an unload with uneven chains. The chains drain at different rates, and the shorter ones start showing freshly shifted-in bits while the longest chain still holds captured data. The stimulus first captures an asymmetric pattern in capture mode. It then shifts zeros in for as many cycles as the longest chain, plus one more. On every shift it compares each serial output pin with the captured bit expected at that depth, or with zero once that chain is empty.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic {
        MODE_SCAN    = 1'b0,
        MODE_CAPTURE = 1'b1
    } scan_mode_e;

    function automatic scan_mode_e decode_mode(input logic tc);
        return tc ? MODE_CAPTURE : MODE_SCAN;
    endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  scan_mode_e mode,
    input  logic       d,
    input  logic       sd,
    output logic       q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            unique case (mode)
                MODE_CAPTURE: q <= d;
                MODE_SCAN:    q <= sd;
                default:      q <= d;
            endcase
        end
    end

endmodule

// File: rtl/scan_chain.sv
module scan_chain
    import scan_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  scan_mode_e     mode,
    input  logic [LEN-1:0] d,
    input  logic           si,
    output logic [LEN-1:0] q,
    output logic           so
);

    logic [LEN-1:0] sd_link;

    always_comb begin
        sd_link[0] = si;
        for (int i = 1; i < LEN; i++) begin
            sd_link[i] = q[i-1];
        end
    end

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        scan_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .d    (d[i]),
            .sd   (sd_link[i]),
            .q    (q[i])
        );
    end

    assign so = q[LEN-1];

    AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SCAN) |=> (q[0] == $past(si))); // R2

    for (genvar i = 1; i < LEN; i++) begin : g_step_chk
        AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_SCAN) |=> (q[i] == $past(q[i-1]))); // R2
    end

endmodule

// File: rtl/scan_pin_mux.sv
module scan_pin_mux
    import scan_pkg::*;
#(
    parameter int NUM_PI = 4,
    parameter int NUM_PO = 4,
    parameter int NUM_CHAINS = 3
) (
    input  scan_mode_e            mode,
    input  logic [NUM_PI-1:0]     pi_pin,
    output logic [NUM_PI-1:0]     pi_func,
    output logic [NUM_CHAINS-1:0] chain_si,
    input  logic [NUM_CHAINS-1:0] chain_so,
    input  logic [NUM_PO-1:0]     po_func,
    output logic [NUM_PO-1:0]     po_pin
);

    always_comb begin
        pi_func  = pi_pin;
        chain_si = pi_pin[NUM_CHAINS-1:0];
        po_pin   = po_func;
        unique case (mode)
            MODE_SCAN:    po_pin[NUM_CHAINS-1:0] = chain_so;
            MODE_CAPTURE: po_pin[NUM_CHAINS-1:0] = po_func[NUM_CHAINS-1:0];
            default:      po_pin[NUM_CHAINS-1:0] = po_func[NUM_CHAINS-1:0];
        endcase
    end

endmodule

// File: rtl/scan_bank.sv
module scan_bank
    import scan_pkg::*;
#(
    parameter int NUM_CHAINS = 3,
    parameter int LEN_W = 8,
    parameter logic [NUM_CHAINS*LEN_W-1:0] CHAIN_LENS = {8'd2, 8'd3, 8'd4},
    parameter int NUM_PI = 4,
    parameter int NUM_PO = 4,
    localparam int NBITS = sum_lens(NUM_CHAINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_ctl,
    input  logic [NBITS-1:0]  func_d,
    output logic [NBITS-1:0]  q,
    input  logic [NUM_PI-1:0] pi_pin,
    output logic [NUM_PI-1:0] pi_func,
    input  logic [NUM_PO-1:0] po_func,
    output logic [NUM_PO-1:0] po_pin
);

    function automatic int len_of(input int k);
        return int'(CHAIN_LENS[k*LEN_W +: LEN_W]);
    endfunction

    function automatic int sum_lens(input int upto);
        int acc = 0;
        for (int j = 0; j < upto; j++) begin
            acc += int'(CHAIN_LENS[j*LEN_W +: LEN_W]);
        end
        return acc;
    endfunction

    scan_mode_e            mode;
    logic [NUM_CHAINS-1:0] chain_si;
    logic [NUM_CHAINS-1:0] chain_so;

    assign mode = decode_mode(test_ctl);

    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
        localparam int L = len_of(k);
        localparam int O = sum_lens(k);

        scan_chain #(.LEN(L)) u_chain (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .d    (func_d[O +: L]),
            .si   (chain_si[k]),
            .q    (q[O +: L]),
            .so   (chain_so[k])
        );

        AST_SO_LAST: assert property (@(posedge clk) disable iff (rst)
            !test_ctl |-> (po_pin[k] == q[O+L-1])); // R3
    end

    scan_pin_mux #(
        .NUM_PI     (NUM_PI),
        .NUM_PO     (NUM_PO),
        .NUM_CHAINS (NUM_CHAINS)
    ) u_pins (
        .mode     (mode),
        .pi_pin   (pi_pin),
        .pi_func  (pi_func),
        .chain_si (chain_si),
        .chain_so (chain_so),
        .po_func  (po_func),
        .po_pin   (po_pin)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (q == '0)); // R6

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        test_ctl |=> (q == $past(func_d))); // R1

    AST_PO_NORMAL: assert property (@(posedge clk) disable iff (rst)
        test_ctl |-> (po_pin == po_func)); // R4

    AST_PI_PASS: assert property (@(posedge clk) disable iff (rst)
        pi_func == pi_pin); // R5

endmodule

// File: tb/scan_bank_tb.sv
module scan_bank_tb;

    localparam int NB = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          test_ctl = 1'b1;
    logic [NB-1:0] func_d = '0;
    logic [NB-1:0] q;
    logic [3:0]    pi_pin = '0;
    logic [3:0]    pi_func;
    logic [3:0]    po_func = '0;
    logic [3:0]    po_pin;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    scan_bank u_dut (
        .clk      (clk),
        .rst      (rst),
        .test_ctl (test_ctl),
        .func_d   (func_d),
        .q        (q),
        .pi_pin   (pi_pin),
        .pi_func  (pi_func),
        .po_func  (po_func),
        .po_pin   (po_pin)
    );

    localparam logic [NB-1:0] CAP_VEC [6] = '{
        9'h000, 9'h1FF, 9'h0AA, 9'h155, 9'h10F, 9'h0F0
    };

    localparam int OFF [3] = '{0, 4, 7};
    localparam int LEN [3] = '{4, 3, 2};

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [NB-1:0] shift_ref(input logic [NB-1:0] old, input logic [3:0] pins);
        logic [NB-1:0] n;
        for (int k = 0; k < 3; k++) begin
            n[OFF[k]] = pins[k];
            for (int i = 1; i < LEN[k]; i++) n[OFF[k]+i] = old[OFF[k]+i-1];
        end
        return n;
    endfunction

    initial begin
        logic [NB-1:0] exp_q;
        logic [NB-1:0] pat;
        tick;
        tick;
        check(q == '0, "R6 reset state", q, 0);
        rst = 1'b0;

        for (int v = 0; v < 6; v++) begin
            func_d  = CAP_VEC[v];
            pi_pin  = CAP_VEC[v][3:0];
            po_func = ~CAP_VEC[v][3:0];
            tick;
            check(q == CAP_VEC[v], "R1 capture", q, CAP_VEC[v]);
            check(pi_func == pi_pin, "R5 input pass", pi_func, pi_pin);
            check(po_pin == po_func, "R4 normal pins", po_pin, po_func);
        end

        func_d = 9'h1A5;
        tick;
        exp_q = 9'h1A5;
        test_ctl = 1'b0;
        po_func = 4'b1010;
        for (int s = 0; s < 4; s++) begin
            pi_pin = 4'(s * 5 + 3);
            func_d = (s % 2 == 0) ? 9'h1FF : 9'h000;
            #1;
            check(po_pin[2:0] == {exp_q[8], exp_q[6], exp_q[3]}, "R3 serial out",
                  po_pin[2:0], {exp_q[8], exp_q[6], exp_q[3]});
            check(po_pin[3] == po_func[3], "R4 unshared pin in scan", po_pin[3], po_func[3]);
            check(pi_func == pi_pin, "R5 input pass scan", pi_func, pi_pin);
            exp_q = shift_ref(exp_q, pi_pin);
            tick;
            check(q == exp_q, "R2 shift step, R8 func_d ignored", q, exp_q);
        end

        test_ctl = 1'b1;
        pat = 9'h16B;
        func_d = pat;
        tick;
        test_ctl = 1'b0;
        pi_pin = 4'b0000;
        func_d = 9'h1FF;
        for (int t = 0; t < 5; t++) begin
            #1;
            for (int k = 0; k < 3; k++) begin
                logic e;
                e = (t < LEN[k]) ? pat[OFF[k] + LEN[k] - 1 - t] : 1'b0;
                check(po_pin[k] == e, "R7 uneven unload", po_pin[k], e);
            end
            tick;
        end

        func_d = '0;
        test_ctl = 1'b1;
        func_d = 9'h1FF;
        tick;
        rst = 1'b1;
        test_ctl = 1'b0;
        pi_pin = 4'hF;
        tick;
        check(q == '0, "R6 reset in scan mode", q, 0);
        rst = 1'b0;
        tick;
        check(q == 9'b0_1001_0001, "R2 shift after reset", q, 9'b0_1001_0001);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule